// File: doc/BRIEF.md
# Calendar alarm interrupt generator

This block holds the four alarm fields of a real-time clock (day-of-month, hours, minutes and seconds, all packed BCD). On each one-second update strobe it compares them with the current calendar fields supplied by the clock block. When all four agree and the alarm is enabled, it records an alarm event and pulls an active-low interrupt line. The line is modelled as a level plus a drive enable, so it can be wired as an open-drain output.

The event stays recorded until the host reads the status byte, and that read clears it. The same pin can carry a frequency-test square wave instead of the alarm. While that function is selected, alarm matches are masked. In battery-backup mode the host bus is cut off, but comparison and signalling keep running.

The host reaches the block through a small byte window. Offsets 0x2, 0x3, 0x4 and 0x5 hold the alarm date, hours, minutes and seconds, in that order. These are the low nibbles of the 0x7FF2 to 0x7FF5 locations in the full address space. Offset 0x1 is the control byte and offset 0x0 is the status byte.

Top module: `alarm_irq`

## Requirements
- R1: After reset, `irq_n` is 1, `irq_oe` is 0, the alarm-enable bit is 0, no event is recorded, and all four alarm bytes read 0x00.
- R2: A write with `bus_sel` and `bus_we` high stores `bus_wdata` at `bus_addr`. Offset 0x2 holds date, 0x3 hours, 0x4 minutes, 0x5 seconds, and bit 0 of offset 0x1 is the alarm enable. With `bus_sel` and `bus_re` high, `bus_rdata` shows the addressed byte in the same cycle. Status at offset 0x0 returns the event flag in bit 0. Any other offset, and any cycle without a read, returns 0x00.
- R3: If, at a rising clock edge, `tick_1hz` is high, all four current fields equal the alarm fields, the enable is set and `ft_sel` is low, then an event is recorded at that edge. From that edge on, `irq_n` is 0 and `irq_oe` is 1.
- R4: If any one of the four fields differs, the strobe records no event.
- R5: Fields that match while `tick_1hz` is low record no event.
- R6: A status read clears the event at the edge where the read is sampled, which releases the pin. If a new event is recorded at that same edge, the new event wins.
- R7: While the enable bit is 0, matches are not recorded and the pin is released (`irq_n`=1, `irq_oe`=0). A pending event shows again once the bit is set.
- R8: While `ft_sel` is 1, `irq_n` equals `ft_wave` and `irq_oe` equals its inverse. Alarm matches in that time are not recorded.
- R9: While `on_battery` is 1, host writes and reads have no effect: registers are unchanged, reads do not clear the event, and `bus_rdata` is 0x00. Matches are still recorded and drive the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host select for the register window |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational |
| cur_date | input | 8 | Current day of month, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_sec | input | 8 | Current seconds, BCD |
| tick_1hz | input | 1 | One-cycle clock update strobe |
| on_battery | input | 1 | Battery-backup mode flag |
| ft_sel | input | 1 | Pin carries the frequency-test wave |
| ft_wave | input | 1 | Frequency-test square wave |
| irq_n | output | 1 | Pin level, active low, 1 when released |
| irq_oe | output | 1 | Pin pull-down enable |

## Verification
Inputs are applied on the falling edge. Strobes and matches are registered at the next rising edge, so `irq_n` and `irq_oe` change one rising edge after a strobe. The bench samples them at the falling edge that follows. `bus_rdata` is combinational, so it is sampled 1 ns after the read is applied, before the edge at which a status read clears the event. The state after the clear is then checked at the following falling edge. The frequency-test path is combinational and is checked within the same half cycle in which `ft_wave` changes.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned N_FIELDS = 4;

  // window offsets; the field order follows the alarm location order
  localparam logic [3:0] OFS_STAT  = 4'h0;
  localparam logic [3:0] OFS_CTRL  = 4'h1;
  localparam logic [3:0] OFS_FIELD = 4'h2;

  typedef enum logic [1:0] {
    F_DATE = 2'd0,
    F_HOUR = 2'd1,
    F_MIN  = 2'd2,
    F_SEC  = 2'd3
  } field_e;

  // true when addr falls in the alarm field range
  function automatic logic is_field(input logic [3:0] addr);
    return (addr >= OFS_FIELD) && (addr < OFS_FIELD + 4'(N_FIELDS));
  endfunction

  function automatic logic [1:0] field_index(input logic [3:0] addr);
    logic [3:0] d;
    d = addr - OFS_FIELD;
    return d[1:0];
  endfunction
endpackage

// File: rtl/alarm_irq_regs.sv
module alarm_irq_regs
  import alarm_irq_pkg::*;
#(
  parameter int unsigned DW = FIELD_W,
  parameter int unsigned NF = N_FIELDS,
  parameter int unsigned AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [NF*DW-1:0] alarm_flat,
  output logic             alarm_en
);
  localparam int unsigned FLAT_W = NF * DW;

  logic [FLAT_W-1:0] fields_q;
  logic              en_q;

  for (genvar i = 0; i < NF; i++) begin : g_field
    logic hit_w;
    assign hit_w = wr_evt && is_field(addr) && (field_index(addr) == 2'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fields_q[i*DW +: DW] <= '0;
      else if (hit_w) fields_q[i*DW +: DW] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          en_q <= 1'b0;
    else if (wr_evt && addr == OFS_CTRL) en_q <= wdata[0];
  end

  assign alarm_flat = fields_q;
  assign alarm_en   = en_q;
endmodule

// File: rtl/alarm_irq_cmp.sv
module alarm_irq_cmp #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 4
) (
  input  logic [NF*DW-1:0] alarm_flat,
  input  logic [NF*DW-1:0] now_flat,
  output logic [NF-1:0]    field_eq,
  output logic             hit
);
  for (genvar i = 0; i < NF; i++) begin : g_eq
    assign field_eq[i] = (alarm_flat[i*DW +: DW] == now_flat[i*DW +: DW]);
  end
  assign hit = &field_eq;
endmodule

// File: rtl/alarm_irq_pin.sv
module alarm_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic alarm_en,
  input  logic ft_sel,
  input  logic ft_wave,
  output logic pending,
  output logic irq_n,
  output logic irq_oe
);
  logic pend_q;
  logic pull_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (clr_evt) pend_q <= 1'b0;
  end

  always_comb begin
    if (ft_sel) pull_low = ~ft_wave;
    else        pull_low = pend_q & alarm_en;
  end

  assign pending = pend_q;
  assign irq_oe  = pull_low;
  assign irq_n   = ~pull_low;
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq
  import alarm_irq_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] cur_date,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_sec,
  input  logic          tick_1hz,
  input  logic          on_battery,
  input  logic          ft_sel,
  input  logic          ft_wave,
  output logic          irq_n,
  output logic          irq_oe
);
  localparam int unsigned NF     = N_FIELDS;
  localparam int unsigned FLAT_W = NF * DW;

  logic              host_live;
  logic              wr_evt;
  logic              rd_evt;
  logic              clr_evt;
  logic              set_evt;
  logic              hit_w;
  logic              en_w;
  logic              pend_w;
  logic [NF-1:0]     field_eq_w;
  logic [FLAT_W-1:0] alarm_flat_w;
  logic [FLAT_W-1:0] now_flat_w;

  assign now_flat_w = {cur_sec, cur_min, cur_hour, cur_date};
  assign host_live  = bus_sel & ~on_battery;
  assign wr_evt     = host_live & bus_we;
  assign rd_evt     = host_live & bus_re;
  assign clr_evt    = rd_evt & (bus_addr == OFS_STAT);
  assign set_evt    = tick_1hz & hit_w & en_w & ~ft_sel;

  alarm_irq_regs #(.DW(DW), .NF(NF), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .addr(bus_addr),
    .wdata(bus_wdata), .alarm_flat(alarm_flat_w), .alarm_en(en_w)
  );

  alarm_irq_cmp #(.DW(DW), .NF(NF)) u_cmp (
    .alarm_flat(alarm_flat_w), .now_flat(now_flat_w),
    .field_eq(field_eq_w), .hit(hit_w)
  );

  alarm_irq_pin u_pin (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_evt(clr_evt),
    .alarm_en(en_w), .ft_sel(ft_sel), .ft_wave(ft_wave),
    .pending(pend_w), .irq_n(irq_n), .irq_oe(irq_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_evt) begin
      if (bus_addr == OFS_STAT)      bus_rdata = DW'(pend_w);
      else if (bus_addr == OFS_CTRL) bus_rdata = DW'(en_w);
      else if (is_field(bus_addr))
        bus_rdata = alarm_flat_w[field_index(bus_addr)*DW +: DW];
    end
  end
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk #(
  parameter int unsigned FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1hz,
  input logic          hit,
  input logic          en,
  input logic          ft_sel,
  input logic          ft_wave,
  input logic          on_battery,
  input logic          pending,
  input logic          clr_evt,
  input logic          irq_n,
  input logic          irq_oe,
  input logic [FW-1:0] alarm_flat
);
  logic fire;
  assign fire = tick_1hz && hit && en && !ft_sel;

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) fire |=> pending); // R3
  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(pending) |-> $past(tick_1hz && hit)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_evt && !fire) |=> !pending); // R6
  AST_RELEASED_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en && !ft_sel) |-> (irq_n && !irq_oe)); // R7
  AST_TEST_WAVE: assert property (@(posedge clk) disable iff (!rst_n) ft_sel |-> (irq_n == ft_wave && irq_oe == !ft_wave)); // R8
  AST_BATT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) on_battery |=> ($stable(alarm_flat) && $stable(en))); // R9
endmodule

bind alarm_irq alarm_irq_chk #(.FW(FLAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .hit(hit_w), .en(en_w),
  .ft_sel(ft_sel), .ft_wave(ft_wave), .on_battery(on_battery),
  .pending(pend_w), .clr_evt(clr_evt), .irq_n(irq_n), .irq_oe(irq_oe),
  .alarm_flat(alarm_flat_w)
);

// File: tb/sim_alarm_irq.sv
`timescale 1ns/1ps
module sim_alarm_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_sel = 0, bus_we = 0, bus_re = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] cur_date = '0, cur_hour = '0, cur_min = '0, cur_sec = '0;
  logic       tick_1hz = 0, on_battery = 0, ft_sel = 0, ft_wave = 0;
  logic       irq_n, irq_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cur_date(cur_date), .cur_hour(cur_hour),
    .cur_min(cur_min), .cur_sec(cur_sec), .tick_1hz(tick_1hz),
    .on_battery(on_battery), .ft_sel(ft_sel), .ft_wave(ft_wave),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  // alarm programmed for the table: date 15, 23:59:58
  localparam logic [31:0] ALM = 32'h15_23_59_58;
  // {date,hour,min,sec}, tick, expected event
  localparam logic [33:0] VEC [8] = '{
    {32'h15_23_59_58, 1'b1, 1'b1},
    {32'h16_23_59_58, 1'b1, 1'b0},
    {32'h15_22_59_58, 1'b1, 1'b0},
    {32'h15_23_58_58, 1'b1, 1'b0},
    {32'h15_23_59_59, 1'b1, 1'b0},
    {32'h15_23_59_58, 1'b0, 1'b0},
    {32'h15_23_59_58, 1'b1, 1'b1},
    {32'h00_00_00_00, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  // read, sample combinational data 1 ns later, release at next negedge
  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_re = 1; bus_addr = a;
    #1;
    check(bus_rdata == exp, req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0; bus_re = 0;
  endtask

  task automatic set_now(input logic [31:0] t);
    {cur_date, cur_hour, cur_min, cur_sec} = t;
  endtask

  // one strobe cycle, then result visible at the following negedge
  task automatic pulse(input logic tk);
    @(negedge clk);
    tick_1hz = tk;
    @(negedge clk);
    tick_1hz = 0;
  endtask

  task automatic pin_is(input logic low, input string req);
    check(irq_n == !low && irq_oe == low, req, {irq_n, irq_oe}, {!low, low});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    pin_is(0, "R1");
    rst_n = 1;
    rd(4'h1, 8'h00, "R1 enable");
    rd(4'h0, 8'h00, "R1 status");
    for (int i = 2; i < 6; i++) rd(4'(i), 8'h00, "R1 alarm byte");

    // R2 program and read back
    wr(4'h2, ALM[31:24]); wr(4'h3, ALM[23:16]);
    wr(4'h4, ALM[15:8]);  wr(4'h5, ALM[7:0]);
    wr(4'h1, 8'h01);
    rd(4'h2, 8'h15, "R2 date"); rd(4'h3, 8'h23, "R2 hour");
    rd(4'h4, 8'h59, "R2 min");  rd(4'h5, 8'h58, "R2 sec");
    rd(4'h1, 8'h01, "R2 enable");
    rd(4'h7, 8'h00, "R2 unmapped");

    // table walk: R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      set_now(VEC[v][33:2]);
      pulse(VEC[v][1]);
      pin_is(VEC[v][0], VEC[v][0] ? "R3 fire" : "R4/R5 no fire");
      rd(4'h0, {7'b0, VEC[v][0]}, "R6 status");
      pin_is(0, "R6 cleared");
    end

    // R6 read-clear and new event at same edge: event kept
    set_now(ALM);
    pulse(1);
    @(negedge clk);
    bus_sel = 1; bus_re = 1; bus_addr = 4'h0; tick_1hz = 1;
    @(negedge clk);
    bus_sel = 0; bus_re = 0; tick_1hz = 0;
    pin_is(1, "R6 set wins");
    rd(4'h0, 8'h01, "R6 set wins status");

    // R7 enable clear while pending: released, shows again on enable
    pulse(1);
    wr(4'h1, 8'h00);
    pin_is(0, "R7 released");
    wr(4'h1, 8'h01);
    pin_is(1, "R7 pending shows");
    rd(4'h0, 8'h01, "R7 clear");
    wr(4'h1, 8'h00);
    pulse(1);
    pin_is(0, "R7 ignored");
    wr(4'h1, 8'h01);
    rd(4'h0, 8'h00, "R7 not recorded");

    // R8 frequency-test wave on the pin, matches masked
    @(negedge clk);
    ft_sel = 1; ft_wave = 0;
    #1 check(irq_n == 0 && irq_oe == 1, "R8 wave low", irq_n, 0);
    @(negedge clk);
    ft_wave = 1;
    #1 check(irq_n == 1 && irq_oe == 0, "R8 wave high", irq_n, 1);
    pulse(1);
    @(negedge clk);
    ft_sel = 0;
    #1 pin_is(0, "R8 masked");
    rd(4'h0, 8'h00, "R8 not recorded");

    // R9 battery: writes and reads ignored, alarm keeps working
    @(negedge clk);
    on_battery = 1;
    wr(4'h5, 8'h00);
    wr(4'h1, 8'h00);
    pulse(1);
    pin_is(1, "R9 fires on battery");
    rd(4'h0, 8'h00, "R9 rdata blocked");
    pin_is(1, "R9 read no clear");
    @(negedge clk);
    on_battery = 0;
    rd(4'h5, 8'h58, "R9 write ignored");
    rd(4'h1, 8'h01, "R9 enable kept");
    rd(4'h0, 8'h01, "R9 event kept");
    pin_is(0, "R9 cleared after");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule